// File: doc/BRIEF.md
# Sleep-Mode Entry and Recovery Controller

This controller sits in front of a synchronous memory and manages its low-power sleep state. An active-high sleep request that may change at any time relative to the clock is brought into the clock domain through a flop chain. Once the synchronised request is seen, the controller takes a fixed number of cycles to enter sleep. It holds sleep while the request stays high, then takes a fixed number of cycles to leave. After that it keeps a recovery window open, during which no access may start.

From the moment entry begins until recovery ends, the controller tells the address and write logic to ignore its inputs. This drops any access that is in flight when sleep starts. From entry until the end of the exit phase, it forces the data bus to high impedance. A sticky error flag records two protocol violations: the device is still selected at the cycle entry begins, or an address strobe arrives during recovery. The flag clears only on reset.

Top module: `sleep_ctrl`

## Requirements
- R1: After reset (`rst_n` low, asynchronous), `asleep`, `block_inputs`, `force_hiz` and `proto_err` are all 0.
- R2: `sleep_req` passes through a two-flop synchroniser. If it is high at rising edge e, `block_inputs` is 0 after edge e+1 and 1 after edge e+2. This is the cycle in which entry begins.
- R3: `asleep` rises exactly ENTER_CYCLES cycles after entry begins, and stays 1 while the synchronised request stays high.
- R4: While `block_inputs` is 1 and the controller is not in recovery, `strobe` and `sel_active` have no effect on any output.
- R5: If `sleep_req` is low at edge f while asleep, `asleep` falls after edge f+2. `force_hiz` stays 1 for EXIT_CYCLES more cycles after that, then falls.
- R6: After `force_hiz` falls, `block_inputs` stays 1 for exactly RECOVER_CYCLES cycles, then returns to 0.
- R7: If `sel_active` is 1 at the edge where entry begins, `proto_err` becomes 1 after that edge.
- R8: If `strobe` is 1 at any edge during the recovery window, `proto_err` becomes 1 after that edge.
- R9: Once set, `proto_err` stays 1 until reset.
- R10: `force_hiz` is 1 from the cycle entry begins through the last exit cycle, and is 0 whenever the controller is awake or in recovery.
- R11: An entry, once begun, always completes, even if the request drops during it. The exit then starts as soon as the controller is asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Asynchronous active-high sleep request |
| sel_active | input | 1 | All chip enables currently active |
| strobe | input | 1 | Any address strobe currently active |
| asleep | output | 1 | Sleep state reached |
| block_inputs | output | 1 | Address and write logic must ignore inputs |
| force_hiz | output | 1 | Data bus forced to high impedance |
| proto_err | output | 1 | Sticky protocol violation flag |

## Verification
The bench builds the controller with ENTER_CYCLES=2, EXIT_CYCLES=2 and RECOVER_CYCLES=3. Because recovery then lasts longer than exit, a swapped or shared counter load changes where `block_inputs` falls relative to `force_hiz`. A behavioural model advances a phase number and a countdown and is compared with all four outputs on every cycle. Directed sequences cover a violation at entry, a strobe in recovery, strobes while asleep, a one-cycle request pulse, and a request that drops during entry.

// File: rtl/sleep_ctrl.sv
module sleep_ctrl #(
  parameter int SYNC_STAGES    = 2,
  parameter int ENTER_CYCLES   = 2,
  parameter int EXIT_CYCLES    = 2,
  parameter int RECOVER_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic sel_active,
  input  logic strobe,
  output logic asleep,
  output logic block_inputs,
  output logic force_hiz,
  output logic proto_err
);
  localparam int MAXC0 = (ENTER_CYCLES > EXIT_CYCLES) ? ENTER_CYCLES : EXIT_CYCLES;
  localparam int MAXC  = (MAXC0 > RECOVER_CYCLES) ? MAXC0 : RECOVER_CYCLES;
  localparam int CW    = $clog2(MAXC + 1);

  typedef enum logic [2:0] {AWAKE, ENTERING, SLEEPING, EXITING, RECOVER} phase_t;

  phase_t                 phase;
  logic [CW-1:0]          cnt;
  logic [SYNC_STAGES-1:0] sync;
  logic                   req_s;

  assign req_s = sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[SYNC_STAGES-2:0], sleep_req};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= AWAKE;
      cnt       <= '0;
      proto_err <= 1'b0;
    end else begin
      case (phase)
        AWAKE: if (req_s) begin
          phase <= ENTERING;
          cnt   <= CW'(ENTER_CYCLES - 1);
          if (sel_active) proto_err <= 1'b1;
        end
        ENTERING: if (cnt == '0) phase <= SLEEPING;
                  else           cnt   <= cnt - 1'b1;
        SLEEPING: if (!req_s) begin
          phase <= EXITING;
          cnt   <= CW'(EXIT_CYCLES - 1);
        end
        EXITING: if (cnt == '0) begin
          phase <= RECOVER;
          cnt   <= CW'(RECOVER_CYCLES - 1);
        end else cnt <= cnt - 1'b1;
        RECOVER: begin
          if (strobe) proto_err <= 1'b1;
          if (cnt == '0) phase <= AWAKE;
          else           cnt   <= cnt - 1'b1;
        end
        default: phase <= AWAKE;
      endcase
    end
  end

  assign asleep       = (phase == SLEEPING);
  assign force_hiz    = (phase == ENTERING) || (phase == SLEEPING) || (phase == EXITING);
  assign block_inputs = (phase != AWAKE);

  assert_asleep_guarded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (force_hiz && block_inputs));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  assert_sleep_after_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(force_hiz));
  assert_recover_after_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(block_inputs) |-> (!force_hiz && $past(!force_hiz)));
  assert_recover_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == RECOVER && strobe) |=> proto_err);
  assert_entry_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(block_inputs) |-> $past(req_s));
endmodule

// File: tb/sleep_ctrl_bench.sv
`timescale 1ns/1ps
module sleep_ctrl_bench;
  localparam int EN = 2, EX = 2, RC = 3;

  logic clk = 1'b0, rst_n = 1'b0, sleep_req = 1'b0, sel_active = 1'b0, strobe = 1'b0;
  logic asleep, block_inputs, force_hiz, proto_err;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sleep_ctrl #(.SYNC_STAGES(2), .ENTER_CYCLES(EN), .EXIT_CYCLES(EX), .RECOVER_CYCLES(RC)) u_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sel_active(sel_active), .strobe(strobe),
    .asleep(asleep), .block_inputs(block_inputs), .force_hiz(force_hiz), .proto_err(proto_err));

  // behavioural model: phase 0 awake, 1 entering, 2 asleep, 3 exiting, 4 recovery
  int ph = 0, left = 0;
  bit m_s0 = 0, m_s1 = 0, m_err = 0, r;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; left = 0; m_s0 = 0; m_s1 = 0; m_err = 0;
    end else begin
      r = m_s1; m_s1 = m_s0; m_s0 = sleep_req;
      case (ph)
        0: if (r) begin if (sel_active) m_err = 1; ph = 1; left = EN; end
        1: begin left--; if (left == 0) ph = 2; end
        2: if (!r) begin ph = 3; left = EX; end
        3: begin left--; if (left == 0) begin ph = 4; left = RC; end end
        default: begin if (strobe) m_err = 1; left--; if (left == 0) ph = 0; end
      endcase
    end
  end

  task automatic chk(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(asleep, ph == 2, "R3 asleep vs model");
    chk(force_hiz, ph >= 1 && ph <= 3, "R10 force_hiz vs model");
    chk(block_inputs, ph != 0, "R6 block_inputs vs model");
    chk(proto_err, m_err, "R7 proto_err vs model");
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  task automatic do_reset;
    @(negedge clk); rst_n = 0; sleep_req = 0; sel_active = 0; strobe = 0;
    tick(2);
    chk(asleep, 0, "R1 asleep"); chk(block_inputs, 0, "R1 block");
    chk(force_hiz, 0, "R1 hiz"); chk(proto_err, 0, "R1 err");
    rst_n = 1; tick(1);
  endtask

  initial begin
    do_reset();
    // clean cycle with timing checks
    sleep_req = 1;
    tick(2); chk(block_inputs, 0, "R2 not yet");
    tick(1); chk(block_inputs, 1, "R2 entry begins"); chk(asleep, 0, "R3 entering");
    tick(1); chk(asleep, 0, "R3 entering");
    tick(1); chk(asleep, 1, "R3 asleep");
    tick(4); chk(asleep, 1, "R3 holds");
    sleep_req = 0;
    tick(2); chk(asleep, 1, "R5 still asleep");
    tick(1); chk(asleep, 0, "R5 asleep falls"); chk(force_hiz, 1, "R5 exiting");
    tick(1); chk(force_hiz, 1, "R5 exiting");
    tick(1); chk(force_hiz, 0, "R5 hiz falls"); chk(block_inputs, 1, "R6 recovery");
    tick(RC - 1); chk(block_inputs, 1, "R6 recovery end");
    tick(1); chk(block_inputs, 0, "R6 awake"); chk(proto_err, 0, "R8 no violation");
    strobe = 1; sel_active = 1; tick(3); strobe = 0; sel_active = 0;
    chk(proto_err, 0, "R4 awake strobes harmless");

    // selected at entry
    sel_active = 1; sleep_req = 1; tick(3);
    chk(proto_err, 1, "R7 selected at entry");
    sel_active = 0; tick(4); sleep_req = 0; tick(12);
    chk(proto_err, 1, "R9 sticky");
    do_reset();

    // strobes while asleep ignored, strobe in recovery flagged
    sleep_req = 1; tick(6);
    strobe = 1; sel_active = 1; tick(3);
    chk(proto_err, 0, "R4 ignored while asleep"); chk(asleep, 1, "R4 still asleep");
    strobe = 0; sel_active = 0;
    sleep_req = 0; tick(5);
    chk(block_inputs, 1, "R8 in recovery"); chk(force_hiz, 0, "R8 in recovery");
    strobe = 1; tick(1); strobe = 0;
    chk(proto_err, 1, "R8 strobe in recovery");
    tick(10); chk(proto_err, 1, "R9 sticky");
    do_reset();

    // one-cycle pulse and drop during entry: entry completes then exits
    sleep_req = 1; tick(1); sleep_req = 0;
    tick(4); chk(asleep, 1, "R11 entry completes");
    tick(1); chk(asleep, 0, "R11 exit immediately");
    tick(10);
    sleep_req = 1; tick(4); sleep_req = 0;
    tick(1); chk(asleep, 1, "R11 asleep after drop");
    tick(12); chk(block_inputs, 0, "R11 back awake");
    finish_run();
  end
endmodule